// File: doc/BRIEF.md
# Binary to Decimal Digit Converter

This block turns an 8-bit unsigned binary value (0 to 255) into three binary-coded decimal digits: units, tens and hundreds. Each digit is four bits wide. The converter is a purely combinational network, so the digits follow the input within the same evaluation. It has no clock, no stored state and no divide or subtract loops.

Inside, the value is built up one input bit at a time, starting from the most significant bit. Between two bit insertions, any decimal digit position that holds five or more is corrected by adding three. Once the working value is shifted left, that correction makes the digit carry into the next decimal position at ten rather than at sixteen. A correction cell sits on a digit position only where that digit can actually reach five. For an 8-bit input this comes to exactly seven small identical cells: five on the units position and two on the tens position. The last input bit is wired straight into the units digit.

Top module: `bin2dec8`

## Requirements
- R1: `units_o` equals the input value modulo 10 for every input from 0 to 255.
- R2: `tens_o` equals the input value divided by 10 (integer division), modulo 10, for every input.
- R3: `hundreds_o` equals the input value divided by 100 (integer division) for every input.
- R4: Every digit output is a valid decimal digit, with a code between 0 and 9, for every input.
- R5: `hundreds_o` never exceeds 2, so its bits 3 and 2 are always zero.
- R6: Bit 0 of `units_o` always equals bit 0 of `bin_i`.
- R7: A correction cell given a 4-bit value v from 0 to 9 outputs v+3 when v is 5 or more and outputs v unchanged otherwise. Inside the array, a cell never receives a value above 9.
- R8: The outputs are a combinational function of `bin_i`. A new input value shows on the digits without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bin_i | input | 8 | Unsigned binary value to convert |
| units_o | output | 4 | Decimal units digit |
| tens_o | output | 4 | Decimal tens digit |
| hundreds_o | output | 4 | Decimal hundreds digit |

## Verification
The bench sweeps all 256 input codes. It looks hardest at the carry points 9/10, 99/100 and 199/200 and at the top value 255. If a cell used the wrong threshold, say four or six, or added the wrong amount, the digits there would drift into hex-like codes such as 10 to 15, or they would fail to roll over into the next digit. If a cell were missing or misplaced on the tens position, inputs at 100 and above would come out wrong. A miswired final bit would break the odd/even agreement between the units digit and the input. The correction cell is also swept on its own over the codes 0 to 9, so that a threshold error is caught directly and not only through the digits.

// File: rtl/bin2dec_pkg.sv
package bin2dec_pkg;

  typedef logic [3:0] dec_digit_t;

  // Number of decimal digits needed for the largest value of a w-bit word.
  function automatic int dec_digits_for(input int w);
    longint unsigned top_val;
    int n;
    top_val = (64'd1 << w) - 64'd1;
    n = 0;
    while (top_val > 0) begin
      top_val = top_val / 10;
      n = n + 1;
    end
    if (n == 0) n = 1;
    return n;
  endfunction

  // A digit position needs a correction cell from this stage onward.
  function automatic int first_fix_stage(input int digit_idx);
    return 3 * digit_idx;
  endfunction

endpackage

// File: rtl/dec_fix_cell.sv
module dec_fix_cell (
  input  logic [3:0] val_i,
  output logic [3:0] val_o
);

  logic at_or_above_five;

  assign at_or_above_five = (val_i > 4'd4);
  assign val_o = at_or_above_five ? (val_i + 4'd3) : val_i;

  // R7: the surrounding array must never present a non-decimal code
  always_comb begin
    assert_cell_input_decimal_R7: assert (val_i <= 4'd9)
      else $error("correction cell received %0d", val_i);
  end

endmodule

// File: rtl/dec_fix_stage.sv
module dec_fix_stage #(
  parameter int NDIG      = 3,
  parameter int STAGE_IDX = 0,
  localparam int WORK_W   = 4 * NDIG
) (
  input  logic [WORK_W-1:0] work_i,
  output logic [WORK_W-1:0] work_o
);

  import bin2dec_pkg::*;

  for (genvar d = 0; d < NDIG; d++) begin : g_digit
    if (STAGE_IDX >= first_fix_stage(d)) begin : g_cell
      dec_fix_cell u_cell (
        .val_i (work_i[4*d +: 4]),
        .val_o (work_o[4*d +: 4])
      );
    end else begin : g_pass
      assign work_o[4*d +: 4] = work_i[4*d +: 4];
    end
  end

endmodule

// File: rtl/dec_shift_array.sv
module dec_shift_array #(
  parameter int BIN_W   = 8,
  localparam int NDIG   = bin2dec_pkg::dec_digits_for(BIN_W),
  localparam int WORK_W = 4 * NDIG,
  localparam int NSTG   = BIN_W - 3
) (
  input  logic [BIN_W-1:0]  bin_i,
  output logic [WORK_W-1:0] dec_o
);

  logic [NSTG:0][WORK_W-1:0]   shifted;
  logic [NSTG-1:0][WORK_W-1:0] fixed;

  // first working value: three top input bits under a zero pad
  assign shifted[0] = {{(WORK_W-3){1'b0}}, bin_i[BIN_W-1 -: 3]};

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    dec_fix_stage #(
      .NDIG      (NDIG),
      .STAGE_IDX (s)
    ) u_stage (
      .work_i (shifted[s]),
      .work_o (fixed[s])
    );

    assign shifted[s+1] = {fixed[s][WORK_W-2:0], bin_i[BIN_W-4-s]};

    // R3: the bit pushed out at the top must be empty, or hundreds would be lost
    always_comb begin
      assert_no_lost_bit_R3: assert (fixed[s][WORK_W-1] == 1'b0)
        else $error("stage %0d dropped a set bit", s);
    end
  end

  assign dec_o = shifted[NSTG];

endmodule

// File: rtl/bin2dec8.sv
module bin2dec8 (
  input  logic [7:0] bin_i,
  output logic [3:0] units_o,
  output logic [3:0] tens_o,
  output logic [3:0] hundreds_o
);

  localparam int BIN_W  = 8;
  localparam int NDIG   = bin2dec_pkg::dec_digits_for(BIN_W);
  localparam int WORK_W = 4 * NDIG;

  logic [WORK_W-1:0] dec_all;

  dec_shift_array #(
    .BIN_W (BIN_W)
  ) u_array (
    .bin_i (bin_i),
    .dec_o (dec_all)
  );

  assign units_o    = dec_all[3:0];
  assign tens_o     = dec_all[7:4];
  assign hundreds_o = dec_all[11:8];

  always_comb begin
    // R4: each digit is a decimal code
    assert_digits_decimal_R4: assert ((units_o <= 4'd9) && (tens_o <= 4'd9))
      else $error("non-decimal digit u=%0d t=%0d", units_o, tens_o);
    // R5: hundreds limited to 2 for an 8-bit input
    assert_hundreds_small_R5: assert (hundreds_o <= 4'd2)
      else $error("hundreds digit %0d", hundreds_o);
    // R1 R2 R3: digits recombine to the input value
    assert_value_kept_R1: assert ((int'(hundreds_o) * 100 + int'(tens_o) * 10
                                   + int'(units_o)) == int'(bin_i))
      else $error("digits do not match input %0d", bin_i);
    // R6: parity carried straight through
    assert_lsb_through_R6: assert (units_o[0] == bin_i[0])
      else $error("units parity mismatch");
  end

endmodule

// File: tb/test_bin2dec8.sv
module test_bin2dec8;

  logic       clk;
  logic       rst_n;
  logic [7:0] bin;
  logic [3:0] units, tens, hundreds;
  logic [3:0] cell_in, cell_out;
  int         checks;
  int         fails;
  bit         done;

  bin2dec8 i_bin2dec8 (
    .bin_i      (bin),
    .units_o    (units),
    .tens_o     (tens),
    .hundreds_o (hundreds)
  );

  dec_fix_cell i_cell (
    .val_i (cell_in),
    .val_o (cell_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  task automatic check(input string req, input int act, input int exp, input int stim);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s input=%0d actual=%0d expected=%0d", req, stim, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    checks = 0;
    fails = 0;
    done = 1'b0;
    rst_n = 1'b0;
    bin = 8'd0;
    cell_in = 4'd0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: input zero gives all-zero digits
    check("R1", int'(units), 0, 0);
    check("R2", int'(tens), 0, 0);
    check("R3", int'(hundreds), 0, 0);

    // R7: correction cell alone over the decimal codes
    for (int v = 0; v < 10; v++) begin
      @(negedge clk);
      cell_in = 4'(v);
      #1;
      check("R7", int'(cell_out), (v >= 5) ? v + 3 : v, v);
    end

    // R8: digits follow the input with no clock edge in between
    @(negedge clk);
    bin = 8'd137;
    #1;
    check("R8", int'(hundreds) * 100 + int'(tens) * 10 + int'(units), 137, 137);
    bin = 8'd64;
    #1;
    check("R8", int'(hundreds) * 100 + int'(tens) * 10 + int'(units), 64, 64);

    // full sweep covering 9/10, 99/100, 199/200 and 255
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      bin = 8'(v);
      #1;
      check("R1", int'(units), v % 10, v);
      check("R2", int'(tens), (v / 10) % 10, v);
      check("R3", int'(hundreds), v / 100, v);
      check("R4", int'((units <= 4'd9) && (tens <= 4'd9) && (hundreds <= 4'd9)), 1, v);
      check("R5", int'(hundreds[3:2]), 0, v);
      check("R6", int'(units[0]), v % 2, v);
    end

    done = 1'b1;
    finish_run();
  end

endmodule